// File: doc/BRIEF.md
# Subframe Chip Timing Generator

The block keeps the chip-level time base of a spread-FSK power-line link. A chip tick is eight times the bit rate. Each tick steps a chip position counter that covers one physical subframe: 45 bytes of 8 bits, with 8 chips per bit, for 2880 positions. From the counter value it raises three one-cycle strobes. One marks each new bit, one marks each new byte and one marks the start of the subframe. The framing logic downstream uses these strobes to start serialising or sampling.

The block has no input for link direction. Transmit and receive share the same count, so a change of direction never disturbs or re-aligns the timing. The mains-lock logic can request a restart. The request is held until the next chip tick, and that tick loads position 0 in place of the normal step.

Top module: `tsg_subframe_timer`

## Requirements
- R1: While rst_ni is low, cnt_o is 0 and all three strobes are low. The reset is asynchronous, so a reset in the middle of a run clears the count at once.
- R2: On each rising clock edge with chip_tick_i high, cnt_o moves up by exactly one. With chip_tick_i low the value holds. This also applies to ticks in consecutive cycles.
- R3: cnt_o never exceeds 2879. A tick taken at 2879 returns it to 0, so the pattern repeats every 2880 ticks.
- R4: bit_stb_o is raised only for positions that are multiples of 8 (0, 8, ..., 2872). That gives 360 pulses per subframe.
- R5: byte_stb_o is raised only for positions that are multiples of 64 (0, 64, ..., 2816). That gives 45 pulses per subframe, and each one coincides with a bit pulse.
- R6: frame_stb_o is raised only for position 0, once per subframe, together with the byte and bit pulses.
- R7: A strobe is high for exactly one clock cycle. That cycle is the one right after the edge that took the tick and loaded the matching position. No strobe rises in a cycle that did not follow a tick.
- R8: A one-cycle pulse on restart_i is held without changing cnt_o. The next chip tick then loads 0 and raises all three strobes. A restart that arrives in the same cycle as a tick takes effect on that tick. The pending request clears once it has been used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_tick_i | input | 1 | One-cycle chip tick (8 per bit) |
| restart_i | input | 1 | Request to restart the subframe at the next tick |
| cnt_o | output | 12 | Current chip position, 0 to 2879 |
| bit_stb_o | output | 1 | Bit boundary strobe |
| byte_stb_o | output | 1 | Byte boundary strobe |
| frame_stb_o | output | 1 | Subframe start strobe |

## Verification
The counter is the only long-lived state. A wrong step or a bad wrap shows on cnt_o in the cycle after the tick concerned, and it shifts every later strobe. For this reason the bench compares every position of a full subframe and counts the pulses of each strobe. A lost or stale restart request shows only at the next chip tick. The bench therefore idles between the request and the tick, checks that the count holds during that gap, and then checks for the jump to 0.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  typedef struct packed {
    logic bit_s;
    logic byte_s;
    logic frame_s;
  } tsg_strobe_t;
endpackage

// File: rtl/tsg_chip_counter.sv
module tsg_chip_counter #(
  parameter int CW      = 12,
  parameter int CNT_MAX = 2879
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  output logic [CW-1:0] cnt_o,
  output logic          step_o,
  output logic          pend_o
);
  logic [CW-1:0] cnt_q;
  logic          step_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      step_q <= tick_i;
      if (tick_i) begin
        pend_q <= 1'b0;
        if (restart_i || pend_q || cnt_q == CW'(CNT_MAX)) cnt_q <= '0;
        else                                              cnt_q <= cnt_q + 1'b1;
      end else if (restart_i) begin
        pend_q <= 1'b1;  // hold request until the next tick
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign step_o = step_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/tsg_strobe_decode.sv
module tsg_strobe_decode
  import tsg_pkg::*;
#(
  parameter int CW             = 12,
  parameter int CHIPS_PER_BIT  = 8,
  parameter int CHIPS_PER_BYTE = 64
) (
  input  logic [CW-1:0] cnt_i,
  input  logic          step_i,
  output tsg_strobe_t   strb_o
);
  localparam int BIT_LB  = $clog2(CHIPS_PER_BIT);
  localparam int BYTE_LB = $clog2(CHIPS_PER_BYTE);

  logic bit_hit, byte_hit, frame_hit;

  generate
    if (BIT_LB > 0 && (1 << BIT_LB) == CHIPS_PER_BIT) begin : g_bit_mask
      assign bit_hit = (cnt_i[BIT_LB-1:0] == '0);
    end else begin : g_bit_mod
      assign bit_hit = ((32'(cnt_i) % CHIPS_PER_BIT) == 0);
    end
    if (BYTE_LB > 0 && (1 << BYTE_LB) == CHIPS_PER_BYTE) begin : g_byte_mask
      assign byte_hit = (cnt_i[BYTE_LB-1:0] == '0);
    end else begin : g_byte_mod
      assign byte_hit = ((32'(cnt_i) % CHIPS_PER_BYTE) == 0);
    end
  endgenerate

  assign frame_hit = (cnt_i == '0);

  // strobes only in the cycle after a tick landed on the position
  assign strb_o.bit_s   = step_i & bit_hit;
  assign strb_o.byte_s  = step_i & byte_hit;
  assign strb_o.frame_s = step_i & frame_hit;
endmodule

// File: rtl/tsg_subframe_timer.sv
module tsg_subframe_timer
  import tsg_pkg::*;
#(
  parameter int CHIPS_PER_BIT   = 8,
  parameter int BITS_PER_BYTE   = 8,
  parameter int BYTES_PER_FRAME = 45,
  localparam int CHIPS_PER_BYTE = CHIPS_PER_BIT * BITS_PER_BYTE,
  localparam int FRAME_CHIPS    = CHIPS_PER_BYTE * BYTES_PER_FRAME,
  localparam int CNT_MAX        = FRAME_CHIPS - 1,
  localparam int CW             = $clog2(FRAME_CHIPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          chip_tick_i,
  input  logic          restart_i,
  output logic [CW-1:0] cnt_o,
  output logic          bit_stb_o,
  output logic          byte_stb_o,
  output logic          frame_stb_o
);
  logic        step;
  logic        restart_pend;
  tsg_strobe_t strb;

  tsg_chip_counter #(
    .CW      (CW),
    .CNT_MAX (CNT_MAX)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (chip_tick_i),
    .restart_i (restart_i),
    .cnt_o     (cnt_o),
    .step_o    (step),
    .pend_o    (restart_pend)
  );

  tsg_strobe_decode #(
    .CW             (CW),
    .CHIPS_PER_BIT  (CHIPS_PER_BIT),
    .CHIPS_PER_BYTE (CHIPS_PER_BYTE)
  ) u_dec (
    .cnt_i  (cnt_o),
    .step_i (step),
    .strb_o (strb)
  );

  assign bit_stb_o   = strb.bit_s;
  assign byte_stb_o  = strb.byte_s;
  assign frame_stb_o = strb.frame_s;
endmodule

// File: rtl/tsg_subframe_timer_chk.sv
module tsg_subframe_timer_chk #(
  parameter int CW      = 12,
  parameter int CNT_MAX = 2879
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          chip_tick_i,
  input logic          restart_i,
  input logic          pend_i,
  input logic [CW-1:0] cnt_o,
  input logic          bit_stb_o,
  input logic          byte_stb_o,
  input logic          frame_stb_o
);
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_tick_i && !restart_i && !pend_i && cnt_o != CW'(CNT_MAX)
      |=> cnt_o == CW'($past(cnt_o) + 1'b1));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_tick_i |=> $stable(cnt_o));

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_tick_i && cnt_o == CW'(CNT_MAX) |=> cnt_o == '0);

  assert_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(CNT_MAX));

  assert_nest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_o |-> bit_stb_o);

  assert_nest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> byte_stb_o);

  assert_after_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_o || byte_stb_o || frame_stb_o) |-> $past(chip_tick_i));

  assert_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_tick_i && (restart_i || pend_i) |=> cnt_o == '0 && frame_stb_o);
endmodule

bind tsg_subframe_timer tsg_subframe_timer_chk #(
  .CW      (CW),
  .CNT_MAX (CNT_MAX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chip_tick_i (chip_tick_i),
  .restart_i   (restart_i),
  .pend_i      (restart_pend),
  .cnt_o       (cnt_o),
  .bit_stb_o   (bit_stb_o),
  .byte_stb_o  (byte_stb_o),
  .frame_stb_o (frame_stb_o)
);

// File: tb/tb_tsg_subframe_timer.sv
`timescale 1ns/1ps
module tb_tsg_subframe_timer;
  localparam int FRAME = 2880;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_tick = 1'b0;
  logic        restart = 1'b0;
  logic [11:0] cnt;
  logic        bit_s, byte_s, frame_s;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tsg_subframe_timer dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .chip_tick_i (chip_tick),
    .restart_i   (restart),
    .cnt_o       (cnt),
    .bit_stb_o   (bit_s),
    .byte_stb_o  (byte_s),
    .frame_stb_o (frame_s)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // outputs right after a tick landed on position v
  task automatic chk_pos(input string req, input int v);
    chk(req, "cnt", int'(cnt), v);
    chk(req, "bit strobe", int'(bit_s), int'(v % 8 == 0));
    chk(req, "byte strobe", int'(byte_s), int'(v % 64 == 0));
    chk(req, "frame strobe", int'(frame_s), int'(v == 0));
  endtask

  task automatic tick1();
    @(negedge clk); chip_tick = 1'b1;
    @(negedge clk); chip_tick = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    idle(3);
    chk("R1", "cnt in reset", int'(cnt), 0);
    chk("R1", "strobes in reset", int'({bit_s, byte_s, frame_s}), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk("R1", "cnt after release", int'(cnt), 0);
  endtask

  task automatic t_bits();
    for (int i = 1; i <= 9; i++) begin
      tick1();
      chk_pos((i == 8) ? "R4" : "R2", i);
    end
  endtask

  task automatic t_pulse_idle();
    for (int i = 10; i <= 16; i++) tick1();
    chk("R4", "bit strobe at 16", int'(bit_s), 1);
    idle(1);
    chk("R7", "bit strobe one cycle", int'(bit_s), 0);
    idle(50);
    chk("R2", "cnt held without tick", int'(cnt), 16);
    chk("R7", "no strobe without tick", int'({bit_s, byte_s, frame_s}), 0);
  endtask

  task automatic t_restart_pending();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    idle(4);
    chk("R8", "cnt held while pending", int'(cnt), 16);
    tick1();
    chk_pos("R8", 0);
    tick1();
    chk("R8", "pending cleared", int'(cnt), 1);
  endtask

  task automatic t_restart_with_tick();
    for (int i = 0; i < 4; i++) tick1();
    chk("R2", "cnt before restart", int'(cnt), 5);
    @(negedge clk); chip_tick = 1'b1; restart = 1'b1;
    @(negedge clk); chip_tick = 1'b0; restart = 1'b0;
    #1;
    chk_pos("R8", 0);
  endtask

  task automatic t_full_frame();
    int exp = 0, mism = 0, nb = 0, ny = 0, nf = 0, mx = 0;
    for (int i = 0; i < FRAME; i++) begin
      tick1();
      exp = (exp + 1) % FRAME;
      if (int'(cnt) != exp) mism++;
      if (bit_s != (exp % 8 == 0) || byte_s != (exp % 64 == 0) || frame_s != (exp == 0)) mism++;
      if (int'(cnt) > mx) mx = int'(cnt);
      nb += int'(bit_s); ny += int'(byte_s); nf += int'(frame_s);
    end
    chk("R2", "subframe mismatches", mism, 0);
    chk("R3", "highest position", mx, FRAME - 1);
    chk("R3", "cnt after wrap", int'(cnt), 0);
    chk("R4", "bit pulses", nb, 360);
    chk("R5", "byte pulses", ny, 45);
    chk("R6", "frame pulses", nf, 1);
    chk("R6", "frame strobe at wrap", int'(frame_s), 1);
  endtask

  task automatic t_back_to_back();
    @(negedge clk); chip_tick = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk); #1;
      chk("R2", "back-to-back cnt", int'(cnt), k);
      chk("R7", "no bit strobe off boundary", int'(bit_s), 0);
    end
    chip_tick = 1'b0;
    idle(2);
    chk("R2", "cnt after burst", int'(cnt), 4);
  endtask

  task automatic t_reset_mid();
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1", "async clear mid-run", int'(cnt), 0);
    @(negedge clk); rst_n = 1'b1;
    tick1();
    chk_pos("R2", 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    t_reset();
    t_bits();
    t_pulse_idle();
    t_restart_pending();
    t_restart_with_tick();
    t_full_frame();
    t_back_to_back();
    t_reset_mid();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      summary();
      $finish;
    end
  end
endmodule